// File: doc/BRIEF.md
# Crystal-Rate Trim Divider with Frequency-Test Output

This block divides a 32,768 Hz crystal clock down to a corrected one-second tick. It trims the average rate by stretching or shortening one second per minute. The divider has two stages: a prescaler that divides by 256 and yields a 128 Hz tick, and a second stage that counts 128 of those ticks. Trimming acts on the prescaler stage.

A 64-minute correction cycle repeats without end. A 5-bit magnitude N chooses how many minutes at the head of each cycle are corrected, namely the first 2×N. A sign bit chooses the direction of the correction.

- To slow the clock, one prescaler reload in the first second of a corrected minute is stretched by half a prescaler period. That second gains 128 oscillator cycles.
- To speed the clock up, one prescaler tick is split so that it counts twice. That second loses a full prescaler period, which is 256 oscillator cycles.

A 7-bit control register holds the magnitude, the sign and a frequency-test enable. A new value is only acted on at the next minute boundary. A separate free-running divider produces a 512 Hz square wave on the test output. It does not see the trimming. The test output is gated by the test enable, the oscillator-stop input, the alarm-flag-enable input and the watchdog-steering condition. A power-fail pulse clears the test enable.

The correction is sequenced by a four-state machine. It moves between states only on a minute boundary (MB) or on the first prescaler tick of a minute (PT).

| State | Meaning |
|---|---|
| CS_PLAIN | The current minute is not corrected. |
| CS_ARM_SLOW | A stretch is pending. |
| CS_ARM_FAST | A split is pending. |
| CS_SPENT | The correction for this minute has been applied. |

| Transition | Trigger |
|---|---|
| PLAIN/SPENT → ARM_SLOW | MB into a minute inside the window, with sign 0 |
| PLAIN/SPENT → ARM_FAST | MB into a minute inside the window, with sign 1 |
| PLAIN/SPENT → PLAIN | MB into a minute outside the window, or N = 0 |
| ARM_SLOW/ARM_FAST → SPENT | PT |

Top module: `cal_trim_core`

## Requirements
- R1: After reset, minute_idx is 0 and sec_tick, tick_128hz, cycle_start, cal_minute and ft_out are all 0. The control register clears to 0.
- R2: An uncorrected second lasts exactly PRE×SEC_DIV oscillator cycles, and tick_128hz pulses every PRE cycles. This includes every second when the magnitude is 0, whatever the sign.
- R3: minute_idx counts 0 to 63 and then wraps to 0. cycle_start pulses together with the sec_tick that ends minute 63.
- R4: With ctrl bit 5 = 0 (slow down) and magnitude N ≥ 1, the first second of each corrected minute lasts PRE×SEC_DIV + PRE/2 cycles. The other seconds of that minute are unchanged.
- R5: With ctrl bit 5 = 1 (speed up) and N ≥ 1, the first second of each corrected minute lasts PRE×(SEC_DIV−1) cycles. The other seconds are unchanged.
- R6: The corrected minutes are minutes 0 to 2N−1 of each cycle, where N is ctrl bits 4:0. cal_minute is 1 exactly during those minutes, so never during minute 62 or 63.
- R7: A value written to the control register takes effect only at the next minute boundary. A minute already in progress keeps the correction it started with.
- R8: While the test output is enabled, ft_out toggles every PRE/8 cycles, giving 512 Hz at the default parameters. The calibration setting does not change this rate.
- R9: ft_out carries the wave only when ctrl bit 6 = 1, stop_osc = 0, alarm_flag_en = 0, and either wdog_steer = 1 or wdog_value = 0. Otherwise ft_out is 0.
- R10: A power_fail pulse clears ctrl bit 6, so ft_out stays 0 afterwards. The calibration magnitude and sign are kept.
- R11: While stop_osc is 1, the whole divider chain holds. No sec_tick or tick_128hz is issued, and the interrupted second is lengthened by exactly the stopped cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Crystal oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Write strobe for the control register |
| ctrl_wdata | input | 7 | Control value: bit 6 test enable, bit 5 sign, bits 4:0 magnitude |
| power_fail | input | 1 | Power-down pulse; clears the test enable |
| stop_osc | input | 1 | Oscillator stop; freezes the divider chain |
| alarm_flag_en | input | 1 | Alarm-flag enable; when 1, suppresses the test output |
| wdog_steer | input | 1 | Watchdog steering bit |
| wdog_value | input | 8 | Watchdog register contents |
| sec_tick | output | 1 | One-cycle pulse at the end of each corrected second |
| tick_128hz | output | 1 | One-cycle pulse at each prescaler tick |
| minute_idx | output | 6 | Minute position inside the 64-minute cycle |
| cycle_start | output | 1 | Pulse on the sec_tick that wraps minute 63 to 0 |
| cal_minute | output | 1 | High during a corrected minute |
| ft_out | output | 1 | Frequency-test square wave, gated |

## Verification
The trim is exercised with several settings, each measuring every second of a full 64-minute cycle:

- Magnitude 0 with the speed-up sign shows that the sign alone changes nothing.
- Magnitude 1 slow-down checks the smallest window and the stretch length.
- Magnitude 6 speed-up checks the split length and the window edge at minute 12.
- Magnitude 31 in both directions checks the widest window and confirms that minutes 62 and 63 stay plain.

A second test rewrites the value in the middle of a minute. This separates an immediate effect from an effect deferred to the next boundary. The test output's toggle spacing is measured while a speed-up trim is active, and each gating input is toggled on its own. Stop and power-fail tests confirm that the chain freezes, that the test output is silenced, and that the calibration survives.

// File: rtl/cal_trim_pkg.sv
package cal_trim_pkg;

    localparam int CYCLE_MINUTES = 64;
    localparam int MIN_W         = 6;

    typedef enum logic [1:0] {
        CS_PLAIN    = 2'd0,
        CS_ARM_SLOW = 2'd1,
        CS_ARM_FAST = 2'd2,
        CS_SPENT    = 2'd3
    } cal_state_e;

    typedef struct packed {
        logic       ft_en;
        logic       speed_up;
        logic [4:0] mag;
    } cal_ctrl_t;

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
    parameter int PRE = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic stretch_i,
    input  logic split_i,
    output logic tick_o,
    output logic split_tick_o
);
    localparam int CNT_W = $clog2(PRE + PRE / 2);
    localparam logic [CNT_W-1:0] RELOAD_NORM = CNT_W'(PRE - 1);
    localparam logic [CNT_W-1:0] RELOAD_LONG = CNT_W'(PRE - 1 + PRE / 2);

    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        tick_o       = run_i && (cnt_q == '0);
        split_tick_o = tick_o && split_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= RELOAD_NORM;
        end else if (run_i) begin
            if (cnt_q == '0) begin
                cnt_q <= stretch_i ? RELOAD_LONG : RELOAD_NORM;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // R2
    pre_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

endmodule

// File: rtl/cal_timebase.sv
module cal_timebase
    import cal_trim_pkg::*;
#(
    parameter int SEC_DIV     = 128,
    parameter int SEC_PER_MIN = 60
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             split_i,
    output logic             sec_tick_o,
    output logic             min_bnd_o,
    output logic [MIN_W-1:0] minute_o,
    output logic [MIN_W-1:0] minute_next_o,
    output logic             cycle_start_o
);
    localparam int SUB_W = $clog2(SEC_DIV + 2);
    localparam int SEC_W = $clog2(SEC_PER_MIN);
    localparam logic [SUB_W-1:0] SUB_END  = SUB_W'(SEC_DIV);
    localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SEC_PER_MIN - 1);
    localparam logic [MIN_W-1:0] MIN_LAST = MIN_W'(CYCLE_MINUTES - 1);

    logic [SUB_W-1:0] sub_q;
    logic [SUB_W-1:0] sub_sum;
    logic [SEC_W-1:0] sec_q;
    logic [MIN_W-1:0] min_q;

    always_comb begin
        sub_sum       = sub_q + (split_i ? SUB_W'(2) : SUB_W'(1));
        sec_tick_o    = tick_i && (sub_sum >= SUB_END);
        min_bnd_o     = sec_tick_o && (sec_q == SEC_LAST);
        minute_next_o = (min_q == MIN_LAST) ? '0 : min_q + 1'b1;
        cycle_start_o = min_bnd_o && (min_q == MIN_LAST);
        minute_o      = min_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sub_q <= '0;
        end else if (tick_i) begin
            sub_q <= sec_tick_o ? '0 : sub_sum;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_q <= '0;
            min_q <= '0;
        end else if (sec_tick_o) begin
            if (sec_q == SEC_LAST) begin
                sec_q <= '0;
                min_q <= minute_next_o;
            end else begin
                sec_q <= sec_q + 1'b1;
            end
        end
    end

    // R3
    minute_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (min_bnd_o && minute_o == MIN_LAST) |=> (minute_o == '0));

    // R2
    sec_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick_o |=> !sec_tick_o);

    // R5
    split_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
        split_i |-> !sec_tick_o);

endmodule

// File: rtl/cal_seq.sv
module cal_seq
    import cal_trim_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             min_bnd_i,
    input  logic [MIN_W-1:0] minute_next_i,
    input  logic             tick_i,
    input  logic [4:0]       mag_i,
    input  logic             speed_up_i,
    output logic             stretch_o,
    output logic             split_o,
    output logic             cal_minute_o
);
    cal_state_e state_q;
    cal_state_e state_d;
    cal_state_e pick;

    always_comb begin
        if ((mag_i != '0) && (minute_next_i < {mag_i, 1'b0})) begin
            pick = speed_up_i ? CS_ARM_FAST : CS_ARM_SLOW;
        end else begin
            pick = CS_PLAIN;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_PLAIN, CS_SPENT: begin
                if (min_bnd_i) state_d = pick;
            end
            CS_ARM_SLOW, CS_ARM_FAST: begin
                if (min_bnd_i)   state_d = pick;
                else if (tick_i) state_d = CS_SPENT;
            end
            default: state_d = CS_PLAIN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CS_PLAIN;
        else        state_q <= state_d;
    end

    always_comb begin
        stretch_o    = 1'b0;
        split_o      = 1'b0;
        cal_minute_o = 1'b1;
        unique case (state_q)
            CS_PLAIN:    cal_minute_o = 1'b0;
            CS_ARM_SLOW: stretch_o    = 1'b1;
            CS_ARM_FAST: split_o      = 1'b1;
            CS_SPENT:    cal_minute_o = 1'b1;
            default:     cal_minute_o = 1'b0;
        endcase
    end

    // R4
    arm_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CS_ARM_SLOW || state_q == CS_ARM_FAST) |-> !min_bnd_i);

    // R7
    plain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!min_bnd_i && state_q == CS_PLAIN) |=> (state_q == CS_PLAIN));

endmodule

// File: rtl/cal_ftest.sv
module cal_ftest #(
    parameter int HALF = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic gate_i,
    output logic ft_o
);
    localparam int HALF_W = $clog2(HALF);
    localparam logic [HALF_W-1:0] HALF_LAST = HALF_W'(HALF - 1);

    logic [HALF_W-1:0] cnt_q;
    logic              wave_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            wave_q <= 1'b0;
        end else if (run_i) begin
            if (cnt_q == HALF_LAST) begin
                cnt_q  <= '0;
                wave_q <= ~wave_q;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    always_comb ft_o = gate_i && wave_q;

    // R11
    wave_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> $stable(wave_q));

endmodule

// File: rtl/cal_trim_core.sv
module cal_trim_core
    import cal_trim_pkg::*;
#(
    parameter int PRE         = 256,
    parameter int SEC_DIV     = 128,
    parameter int SEC_PER_MIN = 60
) (
    input  logic       clk_osc,
    input  logic       rst_n,
    input  logic       ctrl_we,
    input  logic [6:0] ctrl_wdata,
    input  logic       power_fail,
    input  logic       stop_osc,
    input  logic       alarm_flag_en,
    input  logic       wdog_steer,
    input  logic [7:0] wdog_value,
    output logic       sec_tick,
    output logic       tick_128hz,
    output logic [5:0] minute_idx,
    output logic       cycle_start,
    output logic       cal_minute,
    output logic       ft_out
);
    localparam int FT_HALF = PRE / 8;

    cal_ctrl_t        ctrl_q;
    logic             run;
    logic             ft_gate;
    logic             pre_tick;
    logic             split_tick;
    logic             stretch;
    logic             split_req;
    logic             min_bnd;
    logic [MIN_W-1:0] minute_next;

    always_ff @(posedge clk_osc or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_we) begin
            ctrl_q       <= cal_ctrl_t'(ctrl_wdata);
            ctrl_q.ft_en <= ctrl_wdata[6] && !power_fail;
        end else if (power_fail) begin
            ctrl_q.ft_en <= 1'b0;
        end
    end

    always_comb begin
        run     = !stop_osc;
        ft_gate = ctrl_q.ft_en && !stop_osc && !alarm_flag_en
                  && (wdog_steer || (wdog_value == 8'd0));
    end

    cal_prescaler #(.PRE(PRE)) i_prescaler (
        .clk          (clk_osc),
        .rst_n        (rst_n),
        .run_i        (run),
        .stretch_i    (stretch),
        .split_i      (split_req),
        .tick_o       (pre_tick),
        .split_tick_o (split_tick)
    );

    cal_timebase #(.SEC_DIV(SEC_DIV), .SEC_PER_MIN(SEC_PER_MIN)) i_timebase (
        .clk           (clk_osc),
        .rst_n         (rst_n),
        .tick_i        (pre_tick),
        .split_i       (split_tick),
        .sec_tick_o    (sec_tick),
        .min_bnd_o     (min_bnd),
        .minute_o      (minute_idx),
        .minute_next_o (minute_next),
        .cycle_start_o (cycle_start)
    );

    cal_seq i_seq (
        .clk           (clk_osc),
        .rst_n         (rst_n),
        .min_bnd_i     (min_bnd),
        .minute_next_i (minute_next),
        .tick_i        (pre_tick),
        .mag_i         (ctrl_q.mag),
        .speed_up_i    (ctrl_q.speed_up),
        .stretch_o     (stretch),
        .split_o       (split_req),
        .cal_minute_o  (cal_minute)
    );

    cal_ftest #(.HALF(FT_HALF)) i_ftest (
        .clk    (clk_osc),
        .rst_n  (rst_n),
        .run_i  (run),
        .gate_i (ft_gate),
        .ft_o   (ft_out)
    );

    always_comb tick_128hz = pre_tick;

    // R10
    pf_clear_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
        power_fail |=> !ft_out);

    // R11
    stop_quiet_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
        stop_osc |-> (!sec_tick && !tick_128hz));

    // R6
    cal_span_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
        cal_minute |-> (minute_idx < 6'd62));

    // R3
    cycle_tick_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
        cycle_start |-> (sec_tick && minute_idx == 6'd63));

endmodule

// File: tb/test_cal_trim_core.sv
`timescale 1ns/1ps
module test_cal_trim_core;

    localparam int PRE    = 16;
    localparam int SDIV   = 4;
    localparam int SPM    = 2;
    localparam int SEC    = PRE * SDIV;
    localparam int SLOW_S = SEC + PRE / 2;
    localparam int FAST_S = SEC - PRE;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_we = 1'b0;
    logic [6:0] ctrl_wdata = '0;
    logic       power_fail = 1'b0;
    logic       stop_osc = 1'b0;
    logic       alarm_flag_en = 1'b0;
    logic       wdog_steer = 1'b1;
    logic [7:0] wdog_value = 8'd0;
    logic       sec_tick, tick_128hz, cycle_start, cal_minute, ft_out;
    logic [5:0] minute_idx;

    int n_checks = 0;
    int n_fail   = 0;
    bit cur_sign = 1'b0;
    int cur_mag  = 0;

    always #10 clk = ~clk;

    cal_trim_core #(.PRE(PRE), .SEC_DIV(SDIV), .SEC_PER_MIN(SPM)) i_cal_trim_core (
        .clk_osc(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .power_fail(power_fail), .stop_osc(stop_osc), .alarm_flag_en(alarm_flag_en),
        .wdog_steer(wdog_steer), .wdog_value(wdog_value), .sec_tick(sec_tick),
        .tick_128hz(tick_128hz), .minute_idx(minute_idx), .cycle_start(cycle_start),
        .cal_minute(cal_minute), .ft_out(ft_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_ctrl(input bit ft, input bit sign, input int mag);
        ctrl_wdata = {ft, sign, 5'(mag)};
        ctrl_we    = 1'b1;
        cur_sign   = sign;
        cur_mag    = mag;
        @(negedge clk);
        ctrl_we    = 1'b0;
    endtask

    task automatic wait_tick(output int len);
        len = 0;
        do begin
            @(negedge clk);
            len++;
        end while (!sec_tick);
    endtask

    task automatic sync_cycle();
        do @(negedge clk); while (!cycle_start);
    endtask

    function automatic int first_len(input bit sign, input int mag, input int m);
        if (mag != 0 && m < 2 * mag) return sign ? FAST_S : SLOW_S;
        return SEC;
    endfunction

    task automatic to_min_boundary(output int m_next);
        int prev = -1;
        int len;
        while (1) begin
            wait_tick(len);
            if (int'(minute_idx) == prev) break;
            prev = int'(minute_idx);
        end
        m_next = (int'(minute_idx) + 1) % 64;
    endtask

    task automatic count_edges(input int n, output int e);
        logic prev;
        @(negedge clk);
        prev = ft_out;
        e = 0;
        repeat (n) begin
            @(negedge clk);
            if (ft_out !== prev) e++;
            prev = ft_out;
        end
    endtask

    // R1: state right after reset
    task automatic t_reset();
        check(minute_idx == 6'd0, "R1 minute_idx", int'(minute_idx), 0);
        check(!sec_tick && !tick_128hz && !cycle_start, "R1 pulses", int'(sec_tick), 0);
        check(!cal_minute, "R1 cal_minute", int'(cal_minute), 0);
        check(!ft_out, "R1 ft_out", int'(ft_out), 0);
    endtask

    // R2: prescaler tick spacing
    task automatic t_tick128();
        int len;
        do @(negedge clk); while (!tick_128hz);
        for (int k = 0; k < 3; k++) begin
            len = 0;
            do begin @(negedge clk); len++; end while (!tick_128hz);
            check(len == PRE, "R2 tick_128hz period", len, PRE);
        end
    endtask

    // R2 R3 R4 R5 R6: every second of a full cycle
    task automatic run_cycle(input bit sign, input int mag);
        int len;
        int exp;
        write_ctrl(1'b1, sign, mag);
        sync_cycle();
        for (int m = 0; m < 64; m++) begin
            for (int s = 0; s < SPM; s++) begin
                wait_tick(len);
                exp = (s == 0) ? first_len(sign, mag, m) : SEC;
                check(len == exp, (exp == SEC) ? "R2 second length" :
                      (sign ? "R5 shortened second" : "R4 stretched second"), len, exp);
                check(int'(minute_idx) == m, "R3 minute index", int'(minute_idx), m);
                if (s == 0)
                    check(cal_minute == (mag != 0 && m < 2 * mag), "R6 cal_minute",
                          int'(cal_minute), int'(mag != 0 && m < 2 * mag));
            end
        end
        check(cycle_start == 1'b1, "R3 cycle_start at wrap", int'(cycle_start), 1);
    endtask

    // R8 R9: test output rate and gating
    task automatic t_ftest();
        int e;
        int run;
        logic prev;
        bit first;
        wdog_steer = 1'b1; wdog_value = 8'd7; alarm_flag_en = 1'b0;
        count_edges(16, e);
        check(e == 8, "R9 enabled via steer", e, 8);
        @(negedge clk);
        prev = ft_out; run = 0; first = 1'b1;
        repeat (300) begin
            @(negedge clk);
            run++;
            if (ft_out !== prev) begin
                if (!first) check(run == PRE / 8, "R8 half period under trim", run, PRE / 8);
                first = 1'b0; run = 0; prev = ft_out;
            end
        end
        wdog_steer = 1'b0; wdog_value = 8'd0;
        count_edges(16, e);
        check(e == 8, "R9 enabled via zero watchdog", e, 8);
        wdog_value = 8'd3;
        count_edges(16, e);
        check(e == 0 && !ft_out, "R9 blocked by watchdog", e, 0);
        wdog_steer = 1'b1; alarm_flag_en = 1'b1;
        count_edges(16, e);
        check(e == 0 && !ft_out, "R9 blocked by alarm enable", e, 0);
        alarm_flag_en = 1'b0;
        write_ctrl(1'b0, cur_sign, cur_mag);
        count_edges(16, e);
        check(e == 0 && !ft_out, "R9 blocked by test bit", e, 0);
        write_ctrl(1'b1, cur_sign, cur_mag);
    endtask

    // R10: power fail clears test enable, keeps trim
    task automatic t_powerfail();
        int e;
        int mn;
        int len;
        count_edges(16, e);
        check(e == 8, "R10 wave before power fail", e, 8);
        power_fail = 1'b1;
        @(negedge clk);
        power_fail = 1'b0;
        count_edges(32, e);
        check(e == 0 && !ft_out, "R10 wave after power fail", e, 0);
        to_min_boundary(mn);
        wait_tick(len);
        check(len == first_len(cur_sign, cur_mag, mn), "R10 trim retained", len,
              first_len(cur_sign, cur_mag, mn));
    endtask

    // R11: stop freezes the chain
    task automatic t_stop();
        int mn;
        int len;
        int quiet = 1;
        logic [5:0] m0;
        to_min_boundary(mn);
        wait_tick(len);
        @(negedge clk);
        m0 = minute_idx;
        stop_osc = 1'b1;
        repeat (100) begin
            @(negedge clk);
            if (sec_tick || tick_128hz || ft_out || minute_idx != m0) quiet = 0;
        end
        stop_osc = 1'b0;
        check(quiet == 1, "R11 no activity while stopped", quiet, 1);
        wait_tick(len);
        check(1 + 100 + len == SEC + 100, "R11 second lengthened by stop", 1 + 100 + len, SEC + 100);
    endtask

    // R7: mid-minute rewrite defers to next boundary
    task automatic t_retime();
        int len;
        int exp;
        write_ctrl(1'b0, 1'b0, 1);
        sync_cycle();
        wait_tick(len);
        check(len == SLOW_S, "R7 old value minute 0", len, SLOW_S);
        write_ctrl(1'b0, 1'b1, 2);
        wait_tick(len);
        check(len + 1 == SEC, "R7 rest of minute 0 untouched", len + 1, SEC);
        for (int m = 1; m < 5; m++) begin
            wait_tick(len);
            exp = (m < 4) ? FAST_S : SEC;
            check(len == exp, "R7 new value from minute 1", len, exp);
            check(cal_minute == (m < 4), "R7 cal_minute", int'(cal_minute), int'(m < 4));
            wait_tick(len);
            check(len == SEC, "R7 second 2", len, SEC);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_tick128();
        run_cycle(1'b1, 0);
        run_cycle(1'b0, 1);
        run_cycle(1'b1, 6);
        run_cycle(1'b0, 31);
        run_cycle(1'b1, 31);
        t_ftest();
        t_powerfail();
        t_stop();
        t_retime();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule